// File: doc/BRIEF.md
# TMDS Video Channel Encoder

This block turns one colour component of a pixel stream into the 10-bit line symbols of a single TMDS lane. On every pixel clock it looks at a data-enable flag. When the flag is high, the 8-bit component is first recoded to reduce the number of transitions, and a ninth bit records which recoding was used. A tenth bit then decides whether the low byte is sent inverted. That decision steers the running difference between ones and zeros on the lane back towards zero.

When data-enable is low, the byte is ignored and one of four fixed control tokens is sent. The token is chosen by two control bits. On the blue lane these two bits carry horizontal and vertical sync. A full transmitter uses three copies of the block, one per colour. The serialiser and the output stage sit downstream of it.

Top module: `tmds_chan_enc`

## Requirements
- R1: While rst_ni is low, sym_o is the control token 10'b1101010100. The running disparity is zero, so the first video symbol after reset follows the zero-disparity rule of R6.
- R2: A cycle with de_i low yields, one clock later, the token selected by ctrl_i = {c1,c0}: 00 -> 10'b1101010100, 01 -> 10'b0010101011, 10 -> 10'b0101010100, 11 -> 10'b1010101011.
- R3: While de_i is low, data_i has no effect on sym_o.
- R4: Symbol bit 8 is 0 (XNOR recoding) when the byte has more than four ones, or exactly four ones with bit 0 clear. Otherwise bit 8 is 1 (XOR recoding).
- R5: The recoding keeps bit 0 and chains each later bit with its lower neighbour. Undoing the inversion flagged by bit 9 and the chaining flagged by bit 8 returns the original byte.
- R6: If the running disparity is zero or the recoded byte has exactly four ones, bit 9 is the complement of bit 8, and bits 7:0 are inverted exactly when bit 8 is 0.
- R7: Otherwise bit 9 is 1 and bits 7:0 are inverted when the byte's excess of ones has the same sign as the running disparity. In the other case both stay 0 and uninverted.
- R8: The running disparity is a signed 5-bit count. Each video symbol adds its number of ones minus its number of zeros over all 10 bits. Every control cycle sets it to zero.
- R9: sym_o is registered: inputs sampled at one rising edge appear on sym_o after that edge and not before.
- R10: While de_i is high, ctrl_i has no effect on sym_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | High for active video, low for control period |
| data_i | input | 8 | Colour component |
| ctrl_i | input | 2 | Control bits {c1,c0}, used while de_i is low |
| sym_o | output | 10 | Encoded lane symbol |

## Verification
A stuck or miscounted disparity register leaves the tokens and bit 8 intact. It shows up only in bit 9 and in the polarity of bits 7:0. It appears on the first video symbol whose decision depends on the sign of the disparity, which is usually within two or three pixels of a run of unbalanced bytes. A disparity that is not cleared by control cycles is exposed by the first pixel after any blanking. There, a repeated byte must reproduce the same symbol it produced after the previous blanking. Recoding faults corrupt the decoded byte on the very cycle they occur.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int DATA_W = 8;
  localparam int SYM_W  = DATA_W + 2;
  localparam int DISP_W = 5;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef logic [SYM_W-1:0]         sym_t;
  typedef logic signed [DISP_W-1:0] disp_t;

  localparam sym_t TOK_00 = 10'b1101010100;
  localparam sym_t TOK_01 = 10'b0010101011;
  localparam sym_t TOK_10 = 10'b0101010100;
  localparam sym_t TOK_11 = 10'b1010101011;
endpackage

// File: rtl/tmds_minxfer.sv
module tmds_minxfer
  import tmds_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W:0]   qm_o
);
  logic [CNT_W-1:0]  ones;
  logic              use_xnor;
  logic [DATA_W-1:0] chain;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(data_i[i]);
  end

  assign use_xnor = (ones > CNT_W'(DATA_W/2)) ||
                    ((ones == CNT_W'(DATA_W/2)) && !data_i[0]);

  always_comb begin
    chain[0] = data_i[0];
    for (int i = 1; i < DATA_W; i++)
      chain[i] = use_xnor ? ~(chain[i-1] ^ data_i[i]) : (chain[i-1] ^ data_i[i]);
  end

  assign qm_o = {~use_xnor, chain};
endmodule

// File: rtl/tmds_dc_bal.sv
module tmds_dc_bal
  import tmds_pkg::*;
(
  input  logic [DATA_W:0] qm_i,
  input  disp_t           disp_i,
  output sym_t            sym_o,
  output disp_t           disp_o
);
  logic              mode;
  logic [DATA_W-1:0] low;

  assign mode = qm_i[DATA_W];
  assign low  = qm_i[DATA_W-1:0];

  always_comb begin
    int n1, bal, cur, nxt;
    n1 = 0;
    for (int i = 0; i < DATA_W; i++) n1 = n1 + int'(low[i]);
    bal = 2 * n1 - DATA_W;
    cur = int'(disp_i);
    if (cur == 0 || bal == 0) begin
      sym_o = {~mode, mode, (mode ? low : ~low)};
      nxt   = mode ? cur + bal : cur - bal;
    end else if ((cur > 0 && bal > 0) || (cur < 0 && bal < 0)) begin
      sym_o = {1'b1, mode, ~low};
      nxt   = cur - bal + (mode ? 2 : 0);
    end else begin
      sym_o = {1'b0, mode, low};
      nxt   = cur + bal - (mode ? 0 : 2);
    end
    disp_o = disp_t'(nxt);
  end
endmodule

// File: rtl/tmds_ctl_tok.sv
module tmds_ctl_tok
  import tmds_pkg::*;
(
  input  logic [1:0] ctrl_i,
  output sym_t       tok_o
);
  always_comb begin
    unique case (ctrl_i)
      2'b00:   tok_o = TOK_00;
      2'b01:   tok_o = TOK_01;
      2'b10:   tok_o = TOK_10;
      default: tok_o = TOK_11;
    endcase
  end
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc
  import tmds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        ctrl_i,
  output logic [SYM_W-1:0]  sym_o
);
  logic [DATA_W:0] qm;
  sym_t            vid_sym, tok, sym_q;
  disp_t           disp_q, disp_nxt;

  tmds_minxfer u_minxfer (.data_i(data_i), .qm_o(qm));

  tmds_dc_bal u_bal (
    .qm_i  (qm),
    .disp_i(disp_q),
    .sym_o (vid_sym),
    .disp_o(disp_nxt)
  );

  tmds_ctl_tok u_tok (.ctrl_i(ctrl_i), .tok_o(tok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= TOK_00;
      disp_q <= '0;
    end else if (de_i) begin
      sym_q  <= vid_sym;
      disp_q <= disp_nxt;
    end else begin
      sym_q  <= tok;
      disp_q <= '0;   // balance restarts every blanking cycle
    end
  end

  assign sym_o = sym_q;
endmodule

// File: rtl/tmds_chan_enc_chk.sv
module tmds_chan_enc_chk
  import tmds_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              de_i,
  input logic [DATA_W-1:0] data_i,
  input logic [1:0]        ctrl_i,
  input logic [SYM_W-1:0]  sym_o,
  input disp_t             disp_i
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  function automatic sym_t tok_of(logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] unpack(sym_t s);
    logic [DATA_W-1:0] q, d;
    q = s[SYM_W-1] ? ~s[DATA_W-1:0] : s[DATA_W-1:0];
    d[0] = q[0];
    for (int i = 1; i < DATA_W; i++)
      d[i] = s[DATA_W] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return d;
  endfunction

  function automatic logic xor_mode(logic [DATA_W-1:0] d);
    int n = $countones(d);
    return !((n > DATA_W/2) || (n == DATA_W/2 && !d[0]));
  endfunction

  a_r2_ctrl_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(de_i)) |-> (sym_o == tok_of($past(ctrl_i))));

  a_r8_disp_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(de_i)) |-> (disp_i == '0));

  a_r8_disp_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(de_i)) |->
      (int'(disp_i) == int'($past(disp_i)) + 2 * $countones(sym_o) - SYM_W));

  a_r5_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(de_i)) |-> (unpack(sym_o) == $past(data_i)));

  a_r4_mode_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(de_i)) |-> (sym_o[DATA_W] == xor_mode($past(data_i))));
endmodule

bind tmds_chan_enc tmds_chan_enc_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .de_i  (de_i),
  .data_i(data_i),
  .ctrl_i(ctrl_i),
  .sym_o (sym_o),
  .disp_i(disp_q)
);

// File: tb/tmds_chan_enc_test.sv
`timescale 1ns/1ps
module tmds_chan_enc_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       de_i;
  logic [7:0] data_i;
  logic [1:0] ctrl_i;
  logic [9:0] sym_o;

  int n_run  = 0;
  int n_fail = 0;
  int m_disp = 0;

  always #2 clk = ~clk;

  tmds_chan_enc uut (
    .clk_i(clk), .rst_ni(rst_ni), .de_i(de_i),
    .data_i(data_i), .ctrl_i(ctrl_i), .sym_o(sym_o)
  );

  task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_tok(logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic ref_xnor(logic [7:0] d);
    int n = $countones(d);
    return (n > 4) || (n == 4 && !d[0]);
  endfunction

  function automatic logic [9:0] ref_enc(logic de, logic [7:0] d, logic [1:0] c);
    logic [7:0] q;
    logic       m;
    int         bal;
    logic [9:0] s;
    if (!de) begin
      m_disp = 0;
      return ref_tok(c);
    end
    m = ~ref_xnor(d);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = m ? (q[i-1] ^ d[i]) : ~(q[i-1] ^ d[i]);
    bal = 2 * $countones(q) - 8;
    if (m_disp == 0 || bal == 0)
      s = {~m, m, (m ? q : ~q)};
    else if ((m_disp > 0) == (bal > 0))
      s = {1'b1, m, ~q};
    else
      s = {1'b0, m, q};
    m_disp = m_disp + 2 * $countones(s) - 10;
    return s;
  endfunction

  function automatic logic [7:0] ref_dec(logic [9:0] s);
    logic [7:0] q, d;
    q = s[9] ? ~s[7:0] : s[7:0];
    d[0] = q[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return d;
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(logic de, logic [7:0] d, logic [1:0] c, string tag);
    logic [9:0] exp;
    de_i = de; data_i = d; ctrl_i = c;
    exp = ref_enc(de, d, c);
    @(negedge clk);
    chk(tag, sym_o, exp);
    if (de) begin
      chk("R5 decode", {2'b0, ref_dec(sym_o)}, {2'b0, d});
      chk("R4 mode bit", {9'b0, sym_o[8]}, {9'b0, ~ref_xnor(d)});
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    rst_ni = 1'b0; de_i = 1'b1; data_i = 8'hFF; ctrl_i = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 reset token", sym_o, 10'b1101010100);
    rst_ni = 1'b1;

    // R1: first pixel sees zero disparity
    step(1'b1, 8'h01, 2'b00, "R1");
    chk("R1 first pixel", sym_o, 10'b0111111111);
    step(1'b1, 8'h01, 2'b00, "R7");
    chk("R7 invert to rebalance", sym_o, 10'b1100000000);

    // R3/R2: tokens ignore data
    step(1'b0, 8'hA5, 2'b00, "R3");
    chk("R3 token 00", sym_o, 10'b1101010100);
    step(1'b0, 8'h3C, 2'b01, "R3");
    chk("R2 token 01", sym_o, 10'b0010101011);
    step(1'b0, 8'hFF, 2'b10, "R3");
    chk("R2 token 10", sym_o, 10'b0101010100);
    step(1'b0, 8'h00, 2'b11, "R3");
    chk("R2 token 11", sym_o, 10'b1010101011);

    // R8 + R10: disparity cleared, ctrl ignored in video
    step(1'b1, 8'h01, 2'b11, "R10");
    chk("R8 cleared after blanking", sym_o, 10'b0111111111);
    step(1'b1, 8'h01, 2'b10, "R10");
    chk("R10 ctrl ignored", sym_o, 10'b1100000000);

    // R6: balanced recoded byte with nonzero disparity
    step(1'b0, 8'h00, 2'b00, "R2");
    step(1'b1, 8'h00, 2'b00, "R6");
    chk("R6 zero disparity", sym_o, 10'b0100000000);
    step(1'b1, 8'h55, 2'b00, "R6");
    chk("R6 balanced word", sym_o, 10'b0100110011);

    // R4 corner bytes
    step(1'b0, 8'h00, 2'b00, "R2");
    step(1'b1, 8'h00, 2'b00, "R4");
    chk("R4 zero ones xor", {9'b0, sym_o[8]}, 10'd1);
    step(1'b1, 8'hFF, 2'b00, "R4");
    chk("R4 eight ones xnor", {9'b0, sym_o[8]}, 10'd0);
    step(1'b1, 8'h1E, 2'b00, "R4");
    chk("R4 four ones bit0 clear xnor", {9'b0, sym_o[8]}, 10'd0);
    step(1'b1, 8'h0F, 2'b00, "R4");
    chk("R4 four ones bit0 set xor", {9'b0, sym_o[8]}, 10'd1);

    // R9: output changes only after the edge
    step(1'b0, 8'h00, 2'b01, "R2");
    de_i = 1'b1; data_i = 8'h01; ctrl_i = 2'b00;
    #1;
    chk("R9 no combinational path", sym_o, 10'b0010101011);
    void'(ref_enc(1'b0, 8'h00, 2'b00));
    step(1'b1, 8'h01, 2'b00, "R9");
    chk("R9 after edge", sym_o, 10'b0111111111);

    for (int k = 0; k < 4000; k++) begin
      logic de;
      de = ($urandom % 5) != 0;
      step(de, 8'($urandom), 2'($urandom), de ? "R6 R7 random video" : "R2 random token");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule